// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

The monitor counts accepted data beats on a bus and sets them against a cycle counter, so that software can work out how busy a memory port is over a chosen window. It holds four event counters and one cycle counter. Each event counter is pointed at read beats, write beats or both by its own selector. Counters run only while a global enable is set and the start mode is manual. Clearing the global enable freezes every counter at once, so the cycle count and the event counts can be read back as one consistent snapshot.

Software reaches the block through a simple register port: one access per cycle, with read data on the following cycle. Counter enables, overflow flags and interrupt enables each have their own write-one-to-set or write-one-to-clear registers. The last event counter is wider than the others and is read through a low register and a high register. A counter that wraps raises its overflow flag, and the single interrupt line is the OR of the flags whose interrupt enable is set.

Top module: `bus_perf_monitor`

## Requirements
- R1: After reset every register reads as zero, all counters are zero and `irq` is low.
- R2: An access is made by holding `reg_req` high for one cycle (`reg_we` high for a write). A read returns on `reg_rdata` in the next cycle and shows the state from before that clock edge.
- R3: Control register (address 0): bit 0 is the global enable, bit 1 the event-counter reset, bit 2 the cycle-counter reset, and bits 5:4 the start mode. Counting runs only while the enable is 1 and the mode is 00 (manual). Any other mode value keeps every counter stopped. Counting starts on the clock edge after the write that sets the enable.
- R4: Slot numbering: bits 0 to 3 stand for event counters 0 to 3 and bit 4 for the cycle counter. Writing ones to address 1 enables those slots and writing ones to address 2 disables them. Either address reads back the current enable vector.
- R5: Writing bit 1 of the control register zeroes all event counters on that edge, and writing bit 2 zeroes the cycle counter. Neither bit affects the other group. Both bits read back as 0.
- R6: While counting is stopped no counter changes value.
- R7: Selectors for counters 0 to 2 are at addresses 8 to 10 (3 bits). Code 0 counts nothing, 1 counts read beats, 2 counts write beats and 3 counts both. When both strobes are high in the same cycle, the counter adds 2. Codes 4 to 7 count nothing. Counter values are read at addresses 12 to 14 and the cycle counter at address 6.
- R8: Counter 3 (selector at address 11) counts both read and write beats with code 4, while code 3 counts nothing for it; codes 1 and 2 work as for the other counters. It is WIDE_W bits wide (40 by default). Address 15 returns its lower LO_W bits (32 by default) and address 16 returns the remaining upper bits in its low byte.
- R9: Counters wrap modulo 2^width. A wrap sets the slot's bit in the overflow register (address 3). Writing ones to address 3 clears those bits, but a wrap in the same cycle wins. A reset write clears a counter without setting its flag.
- R10: Writing ones to address 4 sets interrupt enables and writing ones to address 5 clears them (both read the enable vector). `irq` is high exactly when some overflow flag has its enable set, and it follows register state one edge after the change.
- R11: Writes to counter addresses (6, 12 to 16) have no effect, and unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after a read |
| rd_beat | input | 1 | A read data beat was accepted this cycle |
| wr_beat | input | 1 | A write data beat was accepted this cycle |
| irq | output | 1 | Overflow interrupt |

## Verification
The properties assume that `reg_req`, `reg_we` and `reg_addr` carry known values in every cycle after reset and that an access lasts a single cycle. The freeze and step properties also assume that only a control-register write can zero a counter while counting is stopped. The stimulus drives every input one half period away from the sampling edge, holds each access for exactly one cycle with an idle cycle after it, and changes the strobe pattern (idle, random, both, read only) only between accesses. This keeps every compared read and every `irq` sample well defined against the cycle-by-cycle model.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
   localparam int N_EVT = 4;
   localparam int SEL_W = 3;

   // word addresses
   localparam int A_CTRL    = 0;
   localparam int A_EN_SET  = 1;
   localparam int A_EN_CLR  = 2;
   localparam int A_OVF     = 3;
   localparam int A_IE_SET  = 4;
   localparam int A_IE_CLR  = 5;
   localparam int A_CYCLE   = 6;
   localparam int A_SEL0    = 8;
   localparam int A_CNT0    = 12;
   localparam int A_WIDE_LO = 15;
   localparam int A_WIDE_HI = 16;

   // control bits
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_ERST_BIT = 1;
   localparam int CTRL_CRST_BIT = 2;
   localparam int CTRL_MODE_LSB = 4;
   localparam logic [1:0] MODE_MANUAL = 2'b00;

   // event select codes
   localparam logic [SEL_W-1:0] SEL_RD        = 3'd1;
   localparam logic [SEL_W-1:0] SEL_WR        = 3'd2;
   localparam logic [SEL_W-1:0] SEL_BOTH      = 3'd3;
   localparam logic [SEL_W-1:0] SEL_BOTH_WIDE = 3'd4;
endpackage

// File: rtl/bpm_evt_decode.sv
module bpm_evt_decode
   import bpm_pkg::*;
#(
   parameter bit WIDE_CODE = 1'b0
)(
   input  logic [SEL_W-1:0] sel,
   input  logic             rd,
   input  logic             wr,
   output logic [1:0]       inc
);
   logic take_rd, take_wr;

   generate
      if (WIDE_CODE) begin : g_wide
         assign take_rd = (sel == SEL_RD) || (sel == SEL_BOTH_WIDE);
         assign take_wr = (sel == SEL_WR) || (sel == SEL_BOTH_WIDE);
      end else begin : g_std
         assign take_rd = (sel == SEL_RD) || (sel == SEL_BOTH);
         assign take_wr = (sel == SEL_WR) || (sel == SEL_BOTH);
      end
   endgenerate

   assign inc = {1'b0, take_rd & rd} + {1'b0, take_wr & wr};
endmodule

// File: rtl/bpm_counter.sv
module bpm_counter #(
   parameter int W = 32
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [1:0]   step,
   output logic [W-1:0] count,
   output logic         wrap
);
   logic [W-1:0] nxt;

   always_comb begin
      {wrap, nxt} = {1'b0, count} + (W+1)'(step);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (clr) count <= '0;
      else          count <= nxt;
   end
endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor
   import bpm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int WIDE_W = 40,
   parameter int LO_W   = 32,
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_req,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              rd_beat,
   input  logic              wr_beat,
   output logic              irq
);
   localparam int NSLOT   = N_EVT + 1;
   localparam int CYC_IDX = N_EVT;
   localparam int HI_W    = WIDE_W - LO_W;

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
      if (HI_W < 1 || HI_W > 8) begin : g_bad_split
         $error("WIDE_W must exceed LO_W by 1 to 8 bits");
      end
      if (LO_W > DATA_W || LO_W < 2) begin : g_bad_lo
         $error("LO_W must lie between 2 and DATA_W");
      end
      if (DATA_W < 8 || ADDR_W < 5) begin : g_bad_port
         $error("DATA_W must be at least 8 and ADDR_W at least 5");
      end
   endgenerate

   logic                          gen_en_q;
   logic [1:0]                    mode_q;
   logic [NSLOT-1:0]              en_q, ovf_q, ie_q;
   logic [N_EVT-1:0][SEL_W-1:0]   sel_q;
   logic [DATA_W-1:0]             rdata_q, rd_mux;
   logic [N_EVT-1:0][1:0]         step;
   logic [NSLOT-1:0]              wrap_raw, wrap_v;
   logic [CNT_W-1:0]              cnt_std [N_EVT-1];
   logic [WIDE_W-1:0]             cnt_wide;
   logic [CNT_W-1:0]              cyc_cnt;
   logic                          run, wr_hit, rd_hit, wr_ctrl, evt_rst, cyc_rst;
   logic                          unused_wdata;

   assign unused_wdata = ^reg_wdata[DATA_W-1:6];

   assign wr_hit  = reg_req && reg_we;
   assign rd_hit  = reg_req && !reg_we;
   assign wr_ctrl = wr_hit && (reg_addr == ADDR_W'(A_CTRL));
   assign evt_rst = wr_ctrl && reg_wdata[CTRL_ERST_BIT];
   assign cyc_rst = wr_ctrl && reg_wdata[CTRL_CRST_BIT];
   assign run     = gen_en_q && (mode_q == MODE_MANUAL);

   // event counters: the last one is the wide variant with its own code
   for (genvar i = 0; i < N_EVT; i++) begin : g_evt
      logic [1:0] inc;
      bpm_evt_decode #(.WIDE_CODE(i == N_EVT-1)) u_dec (
         .sel (sel_q[i]),
         .rd  (rd_beat),
         .wr  (wr_beat),
         .inc (inc)
      );
      assign step[i] = (run && en_q[i]) ? inc : 2'd0;
      if (i == N_EVT-1) begin : g_wide
         bpm_counter #(.W(WIDE_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(evt_rst), .step(step[i]),
            .count(cnt_wide), .wrap(wrap_raw[i])
         );
      end else begin : g_std
         bpm_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .clr(evt_rst), .step(step[i]),
            .count(cnt_std[i]), .wrap(wrap_raw[i])
         );
      end
   end

   bpm_counter #(.W(CNT_W)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(cyc_rst),
      .step({1'b0, run && en_q[CYC_IDX]}),
      .count(cyc_cnt), .wrap(wrap_raw[CYC_IDX])
   );

   // a reset write zeroes without flagging
   assign wrap_v = wrap_raw & ~{cyc_rst, {N_EVT{evt_rst}}};

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         ADDR_W'(A_CTRL):    rd_mux = DATA_W'({mode_q, 3'b000, gen_en_q});
         ADDR_W'(A_EN_SET),
         ADDR_W'(A_EN_CLR):  rd_mux = DATA_W'(en_q);
         ADDR_W'(A_OVF):     rd_mux = DATA_W'(ovf_q);
         ADDR_W'(A_IE_SET),
         ADDR_W'(A_IE_CLR):  rd_mux = DATA_W'(ie_q);
         ADDR_W'(A_CYCLE):   rd_mux = DATA_W'(cyc_cnt);
         ADDR_W'(A_WIDE_LO): rd_mux = DATA_W'(cnt_wide[LO_W-1:0]);
         ADDR_W'(A_WIDE_HI): rd_mux = DATA_W'(cnt_wide[WIDE_W-1:LO_W]);
         default:            rd_mux = '0;
      endcase
      for (int i = 0; i < N_EVT; i++) begin
         if (reg_addr == ADDR_W'(A_SEL0 + i)) rd_mux = DATA_W'(sel_q[i]);
      end
      for (int i = 0; i < N_EVT-1; i++) begin
         if (reg_addr == ADDR_W'(A_CNT0 + i)) rd_mux = DATA_W'(cnt_std[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en_q <= 1'b0;
         mode_q   <= 2'b00;
         en_q     <= '0;
         ovf_q    <= '0;
         ie_q     <= '0;
         sel_q    <= '0;
         rdata_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            gen_en_q <= reg_wdata[CTRL_EN_BIT];
            mode_q   <= reg_wdata[CTRL_MODE_LSB +: 2];
         end
         if (wr_hit && reg_addr == ADDR_W'(A_EN_SET)) en_q <= en_q | reg_wdata[NSLOT-1:0];
         if (wr_hit && reg_addr == ADDR_W'(A_EN_CLR)) en_q <= en_q & ~reg_wdata[NSLOT-1:0];
         if (wr_hit && reg_addr == ADDR_W'(A_IE_SET)) ie_q <= ie_q | reg_wdata[NSLOT-1:0];
         if (wr_hit && reg_addr == ADDR_W'(A_IE_CLR)) ie_q <= ie_q & ~reg_wdata[NSLOT-1:0];
         ovf_q <= (ovf_q & ~((wr_hit && reg_addr == ADDR_W'(A_OVF)) ?
                             reg_wdata[NSLOT-1:0] : '0)) | wrap_v;
         for (int i = 0; i < N_EVT; i++) begin
            if (wr_hit && reg_addr == ADDR_W'(A_SEL0 + i)) sel_q[i] <= reg_wdata[SEL_W-1:0];
         end
         if (rd_hit) rdata_q <= rd_mux;
      end
   end

   assign reg_rdata = rdata_q;
   assign irq       = |(ovf_q & ie_q);
endmodule

// File: rtl/bpm_chk.sv
module bpm_chk
   import bpm_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 5,
   parameter int NSLOT  = 5
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [NSLOT-1:0]  wdata_lo,
   input logic [1:0]        rdata_rst,
   input logic              run,
   input logic [NSLOT-1:0]  en_vec,
   input logic [NSLOT-1:0]  ovf_vec,
   input logic [NSLOT-1:0]  wrap_vec,
   input logic [CNT_W-1:0]  cnt0,
   input logic [CNT_W-1:0]  cyc
);
   logic ctrl_wr;
   assign ctrl_wr = req && we && (addr == ADDR_W'(A_CTRL));

   // R4
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && addr == ADDR_W'(A_EN_SET)) |=> ((en_vec & $past(wdata_lo)) == $past(wdata_lo)));

   // R4
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && addr == ADDR_W'(A_EN_CLR)) |=> ((en_vec & $past(wdata_lo)) == '0));

   // R5
   evt_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && wdata_lo[CTRL_ERST_BIT]) |=> (cnt0 == '0));

   // R3
   rst_bits_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !we && addr == ADDR_W'(A_CTRL)) |=> (rdata_rst == 2'b00));

   // R6
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ctrl_wr) |=> ($stable(cnt0) && $stable(cyc)));

   // R7
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ctrl_wr) |=> (CNT_W'(cnt0 - $past(cnt0)) <= CNT_W'(2)));

   // R9
   ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && addr == ADDR_W'(A_OVF) && wrap_vec == '0) |=> ((ovf_vec & $past(wdata_lo)) == '0));
endmodule

bind bus_perf_monitor bpm_chk #(
   .CNT_W(CNT_W), .ADDR_W(ADDR_W), .NSLOT(NSLOT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we), .addr(reg_addr),
   .wdata_lo(reg_wdata[NSLOT-1:0]), .rdata_rst(reg_rdata[2:1]), .run(run),
   .en_vec(en_q), .ovf_vec(ovf_q), .wrap_vec(wrap_v),
   .cnt0(cnt_std[0]), .cyc(cyc_cnt)
);

// File: tb/bus_perf_monitor_tb_top.sv
module bus_perf_monitor_tb_top;
   localparam int CNT_W  = 8;
   localparam int WIDE_W = 12;
   localparam int LO_W   = 8;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 5;
   localparam longint LIM_STD  = longint'(1) << CNT_W;
   localparam longint LIM_WIDE = longint'(1) << WIDE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_req = 1'b0, reg_we = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic              rd_beat = 1'b0, wr_beat = 1'b0;
   logic              irq;

   bus_perf_monitor #(.CNT_W(CNT_W), .WIDE_W(WIDE_W), .LO_W(LO_W),
                      .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rd_beat(rd_beat), .wr_beat(wr_beat), .irq(irq)
   );

   always #5 clk = ~clk;

   int     total = 0, bad = 0, cycles = 0, pat = 0;
   bit     done = 1'b0;
   string  cur_req = "R1";

   // behavioural reference state
   longint m_cnt [4];
   longint m_cyc;
   int     m_gen, m_mode, m_en, m_ovf, m_ie;
   int     m_sel [4];
   longint exp_rdata;
   bit     rd_pend = 1'b0;

   function automatic longint model_read(int a);
      case (a)
         0:     return longint'((m_mode << 4) | m_gen);
         1, 2:  return longint'(m_en);
         3:     return longint'(m_ovf);
         4, 5:  return longint'(m_ie);
         6:     return m_cyc;
         8, 9, 10, 11: return longint'(m_sel[a-8]);
         12, 13, 14:   return m_cnt[a-12];
         15:    return m_cnt[3] & ((longint'(1) << LO_W) - 1);
         16:    return m_cnt[3] >> LO_W;
         default: return 0;
      endcase
   endfunction

   function automatic int model_inc(int idx, int sel, bit r, bit w);
      bit tr, tw;
      if (idx == 3) begin
         tr = (sel == 1) || (sel == 4);
         tw = (sel == 2) || (sel == 4);
      end else begin
         tr = (sel == 1) || (sel == 3);
         tw = (sel == 2) || (sel == 3);
      end
      return int'(tr && r) + int'(tw && w);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_sel[i] = 0; end
         m_cyc = 0; m_gen = 0; m_mode = 0; m_en = 0; m_ovf = 0; m_ie = 0;
         rd_pend = 1'b0; exp_rdata = 0;
      end else begin
         bit  run, wctl;
         int  wraps, d, a;
         longint s, lim;
         a     = int'(reg_addr);
         d     = int'(reg_wdata);
         wctl  = reg_req && reg_we && a == 0;
         run   = (m_gen == 1) && (m_mode == 0);
         wraps = 0;
         rd_pend = reg_req && !reg_we;
         if (rd_pend) exp_rdata = model_read(a);
         for (int i = 0; i < 4; i++) begin
            lim = (i == 3) ? LIM_WIDE : LIM_STD;
            if (wctl && d[1]) m_cnt[i] = 0;
            else if (run && m_en[i]) begin
               s = m_cnt[i] + model_inc(i, m_sel[i], rd_beat, wr_beat);
               if (s >= lim) begin s = s - lim; wraps = wraps | (1 << i); end
               m_cnt[i] = s;
            end
         end
         if (wctl && d[2]) m_cyc = 0;
         else if (run && m_en[4]) begin
            s = m_cyc + 1;
            if (s >= LIM_STD) begin s = 0; wraps = wraps | 16; end
            m_cyc = s;
         end
         if (reg_req && reg_we) begin
            case (a)
               0: begin m_gen = d & 1; m_mode = (d >> 4) & 3; end
               1: m_en = m_en | (d & 31);
               2: m_en = m_en & ~(d & 31);
               3: m_ovf = m_ovf & ~(d & 31);
               4: m_ie = m_ie | (d & 31);
               5: m_ie = m_ie & ~(d & 31);
               8, 9, 10, 11: m_sel[a-8] = d & 7;
               default: ;
            endcase
         end
         m_ovf = m_ovf | wraps;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (irq !== ((m_ovf & m_ie) != 0)) begin
            bad++;
            $display("FAIL R10 (%s) irq actual=%0b expected=%0b", cur_req, irq, (m_ovf & m_ie) != 0);
         end
         if (rd_pend) begin
            total++;
            if (longint'(reg_rdata) !== exp_rdata) begin
               bad++;
               $display("FAIL %s read actual=%0h expected=%0h", cur_req, reg_rdata, exp_rdata);
            end
         end
      end
   end

   // strobe patterns: 0 idle, 1 random, 2 both, 3 read only
   initial begin
      forever begin
         @(negedge clk);
         case (pat)
            1: begin rd_beat = 1'($urandom); wr_beat = 1'($urandom); end
            2: begin rd_beat = 1'b1; wr_beat = 1'b1; end
            3: begin rd_beat = 1'b1; wr_beat = 1'b0; end
            default: begin rd_beat = 1'b0; wr_beat = 1'b0; end
         endcase
      end
   end

   task automatic access(input bit w, input int a, input int d);
      @(negedge clk);
      reg_req = 1'b1; reg_we = w; reg_addr = ADDR_W'(a); reg_wdata = DATA_W'(d);
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic wr(input int a, input int d); access(1'b1, a, d); endtask
   task automatic rd(input int a); access(1'b0, a, 0); endtask
   task automatic idle(input int n); repeat (n) @(negedge clk); endtask
   task automatic read_all();
      for (int a = 0; a < 18; a++) rd(a);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1"; read_all();
      // R11 writes to counters ignored, unmapped reads zero
      cur_req = "R11";
      for (int a = 12; a < 17; a++) wr(a, 32'hFF);
      wr(6, 32'hFF); wr(7, 32'hFF); read_all();
      // R7 selectors, R4 enables
      cur_req = "R7"; wr(8, 1); wr(9, 2); wr(10, 3); wr(11, 4); rd(8); rd(11);
      cur_req = "R4"; wr(1, 32'h1F); rd(1); rd(2);
      // R3 non-manual mode keeps counters stopped
      cur_req = "R3"; pat = 1; wr(0, 32'h11); idle(20); read_all();
      wr(0, 1); idle(40); read_all();
      // R7 both strobes add 2, read-only pattern
      cur_req = "R7"; pat = 2; idle(30); read_all();
      pat = 3; idle(10); read_all();
      pat = 2; wr(10, 4); wr(11, 3); idle(20); read_all();
      wr(10, 3); wr(11, 4);
      // R6 freeze
      cur_req = "R6"; pat = 1; wr(0, 0); idle(30); read_all(); wr(0, 1);
      // R5 reset bits
      cur_req = "R5"; wr(0, 3); read_all(); idle(10); wr(0, 5); read_all();
      // R4 clear enables
      cur_req = "R4"; wr(2, 5); idle(30); read_all(); wr(1, 5);
      // R8 wide counter split, R9 wrap flags, R10 interrupt
      cur_req = "R10"; wr(4, 32'h1F); pat = 2;
      cur_req = "R8";
      for (int k = 0; k < 12; k++) begin idle(180); rd(15); rd(16); rd(3); end
      cur_req = "R9"; read_all(); wr(3, 32'h0F); rd(3); idle(5); rd(3);
      cur_req = "R10"; wr(5, 32'h10); idle(300); rd(4); rd(3);
      wr(5, 32'h1F); idle(5); wr(3, 32'h1F); rd(3);
      // R2 reads reflect pre-edge state while counting
      cur_req = "R2"; pat = 1; rd(6); rd(12); rd(13); rd(14);
      pat = 0; idle(4);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule